// File: doc/BRIEF.md
# SDRAM Burst Mode Register and Column Sequencer

This block sits between a memory controller's command scheduler and the SDRAM pins. It latches the burst configuration from the address bus when a mode-register-set strobe arrives: burst length, column ordering, CAS latency and whether writes are single-beat. It then turns each read or write start command into a stream of per-beat column addresses. The array itself, refresh and bank timing stay with the surrounding controller.

For writes it produces a write enable for each beat. The data mask applies to the beat in the very cycle it is sampled. For reads it produces a data-valid pulse CAS-latency cycles after each beat, and an output enable that the data mask turns off two cycles after the mask is sampled. A burst stop ends any burst, including an open-ended full-page burst.

Top module: `sdram_burst_seq`

## Requirements
- R1: After reset `col_valid_o`, `wr_en_o`, `rd_valid_o` and `oe_o` are low, and the mode is burst length 1, sequential, CAS latency 2, writes at full burst length.
- R2: On `mrs_i`, address bits [2:0] select the burst length: 000 is 1, 001 is 2, 010 is 4, 011 is 8, 111 is a full page. Any other code makes the whole mode-register-set ignored.
- R3: Address bit 3 selects the ordering (0 sequential, 1 interleaved). A full-page code combined with interleaved ordering is ignored.
- R4: Address bits [6:4] select the CAS latency (010 is 2, 011 is 3; other codes are ignored). `rd_valid_o` is high exactly CAS-latency cycles after each read beat appears on `col_o`.
- R5: A mode-register-set with address bits [8:7] other than 00 leaves the mode unchanged.
- R6: With address bit 9 set, writes issue a single beat at the start column, and reads still run the full burst length.
- R7: Sequential beat i addresses the start column plus i, wrapping inside the block of burst-length columns that holds the start column.
- R8: Interleaved beat i addresses the start column with its low log2(length) bits XORed with i.
- R9: A full-page burst (256 columns) counts up from the start column modulo 256, and continues past 256 beats until stopped.
- R10: When `stop_i` is high in a beat cycle, that beat is the last one issued.
- R11: During a write beat, `wr_en_o` equals the inverse of `dqm_i` in that same cycle.
- R12: `oe_o` is `rd_valid_o` gated off when `dqm_i` was high two cycles earlier.
- R13: A start command or a mode-register-set that arrives while a burst is running is ignored.
- A beat appears on `col_o` with `col_valid_o` high in the cycle after the start command is sampled. Each later beat follows one cycle after the previous one.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| mrs_i | input | 1 | Mode-register-set strobe |
| addr_i | input | ADDR_W (12) | Address bus sampled with `mrs_i` |
| start_i | input | 1 | Burst start command |
| start_write_i | input | 1 | 1 for write burst, 0 for read |
| start_col_i | input | COL_W (8) | Starting column of the burst |
| stop_i | input | 1 | Burst stop |
| dqm_i | input | 1 | Data mask |
| col_o | output | COL_W (8) | Column address of current beat |
| col_valid_o | output | 1 | A beat is issued this cycle |
| wr_en_o | output | 1 | Write data beat enabled this cycle |
| rd_valid_o | output | 1 | Read data returns this cycle |
| oe_o | output | 1 | Read data output driven (low is Hi-Z) |

## Verification
The hardest case to reach is a command arriving in the middle of a running burst. A start and a mode-register-set that land mid-burst must both disappear, with no trace in later bursts. The stimulus raises both in the second beat of a burst. It then runs a further burst that still shows the old length. A full-page burst that must run past 256 beats is also reached on purpose: a 300-beat burst is stopped only at its last beat. Mask timing is exercised by setting the mask on chosen beats under both CAS latencies, so the two-cycle read mask lands on different data beats.

// File: rtl/sbs_pkg.sv
`timescale 1ns/1ps
package sbs_pkg;

    typedef struct packed {
        logic [1:0] len_log;    // log2 of burst length when not full page
        logic       full_page;
        logic       interleave;
        logic [1:0] cas_lat;
        logic       wr_single;
    } mode_t;

    localparam mode_t MODE_RESET = '{
        len_log:    2'd0,
        full_page:  1'b0,
        interleave: 1'b0,
        cas_lat:    2'd2,
        wr_single:  1'b0
    };

endpackage

// File: rtl/sbs_mode_reg.sv
`timescale 1ns/1ps
module sbs_mode_reg
    import sbs_pkg::*;
#(
    parameter int ADDR_W = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              mrs_i,
    input  logic              busy_i,
    input  logic [ADDR_W-1:0] addr_i,
    output mode_t             mode_o
);
    localparam int BT_BIT = 3;
    localparam int CL_LSB = 4;
    localparam int TM_LSB = 7;
    localparam int WB_BIT = 9;

    mode_t mode_d, mode_q;

    logic [2:0] len_code;
    logic [2:0] cl_code;
    logic [1:0] tm_code;
    logic       len_ok, cl_ok, accept;
    logic [1:0] len_log;
    logic       full_page;

    logic unused_rfu;
    assign unused_rfu = ^addr_i[ADDR_W-1:WB_BIT+1];

    always_comb begin
        len_code  = addr_i[2:0];
        cl_code   = addr_i[CL_LSB+2:CL_LSB];
        tm_code   = addr_i[TM_LSB+1:TM_LSB];
        len_ok    = 1'b1;
        full_page = 1'b0;
        len_log   = 2'd0;
        // R2 length decode
        case (len_code)
            3'b000:  len_log = 2'd0;
            3'b001:  len_log = 2'd1;
            3'b010:  len_log = 2'd2;
            3'b011:  len_log = 2'd3;
            3'b111:  full_page = 1'b1;
            default: len_ok = 1'b0;
        endcase
        cl_ok = (cl_code == 3'b010) || (cl_code == 3'b011);
        // R3 full page only with sequential ordering
        accept = mrs_i && !busy_i && len_ok && cl_ok && (tm_code == 2'b00)
                 && !(full_page && addr_i[BT_BIT]);

        mode_d = mode_q;
        if (accept) begin
            mode_d.len_log    = len_log;
            mode_d.full_page  = full_page;
            mode_d.interleave = addr_i[BT_BIT];
            mode_d.cas_lat    = cl_code[1:0];
            mode_d.wr_single  = addr_i[WB_BIT];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) mode_q <= MODE_RESET;
        else        mode_q <= mode_d;
    end

    assign mode_o = mode_q;

    // R5
    tm_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mrs_i && addr_i[TM_LSB+1:TM_LSB] != 2'b00) |=> $stable(mode_q));

    // R13
    busy_mrs_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy_i |=> $stable(mode_q));

    // R4
    cl_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_q.cas_lat == 2'd2) || (mode_q.cas_lat == 2'd3));

endmodule

// File: rtl/sbs_col_gen.sv
`timescale 1ns/1ps
module sbs_col_gen
    import sbs_pkg::*;
#(
    parameter int COL_W = 8
) (
    input  mode_t            mode_i,
    input  logic [COL_W-1:0] start_col_i,
    input  logic [COL_W-1:0] beat_i,
    output logic [COL_W-1:0] col_o,
    output logic [COL_W-1:0] mask_o,
    output logic             last_o
);
    logic [COL_W-1:0] mask;
    logic [COL_W-1:0] offs;

    always_comb begin
        for (int i = 0; i < COL_W; i++) begin
            mask[i] = mode_i.full_page || (i < int'(mode_i.len_log));
        end
        // R7 / R8 ordering inside the aligned block
        if (mode_i.interleave) offs = start_col_i ^ beat_i;
        else                   offs = start_col_i + beat_i;
        col_o  = (start_col_i & ~mask) | (offs & mask);
        mask_o = mask;
        // R9 full page never ends by itself
        last_o = !mode_i.full_page && (beat_i == mask);
    end

endmodule

// File: rtl/sbs_burst_ctl.sv
`timescale 1ns/1ps
module sbs_burst_ctl #(
    parameter int COL_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic             write_i,
    input  logic [COL_W-1:0] col_i,
    input  logic             stop_i,
    input  logic             last_i,
    input  logic             wr_single_i,
    output logic             active_o,
    output logic             write_o,
    output logic [COL_W-1:0] start_col_o,
    output logic [COL_W-1:0] beat_o
);
    typedef struct packed {
        logic             active;
        logic             write;
        logic [COL_W-1:0] start_col;
        logic [COL_W-1:0] beat;
    } st_t;

    st_t st_d, st_q;
    logic finish;

    always_comb begin
        st_d   = st_q;
        finish = stop_i || last_i || (st_q.write && wr_single_i);
        if (st_q.active) begin
            if (finish) st_d.active = 1'b0;
            else        st_d.beat   = st_q.beat + COL_W'(1);
        end else if (start_i) begin
            st_d.active    = 1'b1;
            st_d.write     = write_i;
            st_d.start_col = col_i;
            st_d.beat      = '0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign active_o    = st_q.active;
    assign write_o     = st_q.write;
    assign start_col_o = st_q.start_col;
    assign beat_o      = st_q.beat;

    // R10
    stop_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.active && stop_i) |=> !st_q.active);

    // R13
    busy_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.active && start_i) |=> ($stable(st_q.start_col) && $stable(st_q.write)));

endmodule

// File: rtl/sbs_rd_pipe.sv
`timescale 1ns/1ps
module sbs_rd_pipe #(
    parameter int MAX_CL = 3
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       issue_i,
    input  logic       dqm_i,
    input  logic [1:0] cas_lat_i,
    output logic       rd_valid_o,
    output logic       oe_o
);
    localparam int DQM_LAT = 2;

    typedef struct packed {
        logic [MAX_CL-1:0]  vld;
        logic [DQM_LAT-1:0] dqm;
        logic [1:0]         age;
    } pipe_t;

    pipe_t p_d, p_q;

    always_comb begin
        p_d     = p_q;
        p_d.vld = {p_q.vld[MAX_CL-2:0], issue_i};
        p_d.dqm = {p_q.dqm[DQM_LAT-2:0], dqm_i};
        if (p_q.age != 2'd3) p_d.age = p_q.age + 2'd1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) p_q <= '0;
        else        p_q <= p_d;
    end

    always_comb begin
        rd_valid_o = 1'b0;
        for (int i = 0; i < MAX_CL; i++) begin
            if (int'(cas_lat_i) == i + 1) rd_valid_o = p_q.vld[i];
        end
        oe_o = rd_valid_o && !p_q.dqm[DQM_LAT-1];
    end

    // R12
    oe_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (p_q.age == 2'd3 && $past(dqm_i, 2)) |-> !oe_o);

    // R4
    cl2_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (p_q.age == 2'd3 && cas_lat_i == 2'd2 && rd_valid_o) |-> $past(issue_i, 2));

    // R4
    cl3_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (p_q.age == 2'd3 && cas_lat_i == 2'd3 && rd_valid_o) |-> $past(issue_i, 3));

endmodule

// File: rtl/sdram_burst_seq.sv
`timescale 1ns/1ps
module sdram_burst_seq
    import sbs_pkg::*;
#(
    parameter int ADDR_W = 12,
    parameter int COL_W  = 8,
    parameter int MAX_CL = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              mrs_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic              start_i,
    input  logic              start_write_i,
    input  logic [COL_W-1:0]  start_col_i,
    input  logic              stop_i,
    input  logic              dqm_i,
    output logic [COL_W-1:0]  col_o,
    output logic              col_valid_o,
    output logic              wr_en_o,
    output logic              rd_valid_o,
    output logic              oe_o
);
    mode_t            mode;
    logic             active, cur_write, last;
    logic [COL_W-1:0] start_col, beat, mask;

    sbs_mode_reg #(.ADDR_W(ADDR_W)) u_mode (
        .clk(clk), .rst_n(rst_n), .mrs_i(mrs_i), .busy_i(active),
        .addr_i(addr_i), .mode_o(mode)
    );

    sbs_burst_ctl #(.COL_W(COL_W)) u_ctl (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .write_i(start_write_i),
        .col_i(start_col_i), .stop_i(stop_i), .last_i(last),
        .wr_single_i(mode.wr_single), .active_o(active), .write_o(cur_write),
        .start_col_o(start_col), .beat_o(beat)
    );

    sbs_col_gen #(.COL_W(COL_W)) u_col (
        .mode_i(mode), .start_col_i(start_col), .beat_i(beat),
        .col_o(col_o), .mask_o(mask), .last_o(last)
    );

    sbs_rd_pipe #(.MAX_CL(MAX_CL)) u_rd (
        .clk(clk), .rst_n(rst_n), .issue_i(active && !cur_write),
        .dqm_i(dqm_i), .cas_lat_i(mode.cas_lat),
        .rd_valid_o(rd_valid_o), .oe_o(oe_o)
    );

    assign col_valid_o = active;
    // R11 write mask has zero latency
    assign wr_en_o     = active && cur_write && !dqm_i;

    // R6
    wr_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (col_valid_o && cur_write && mode.wr_single) |=> !col_valid_o);

    // R7
    block_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (col_valid_o && !mode.full_page) |-> (((col_o ^ start_col) & ~mask) == '0));

    // R9
    page_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (col_valid_o && mode.full_page && !stop_i)
        |=> (col_valid_o && col_o == COL_W'($past(col_o) + COL_W'(1))));

endmodule

// File: tb/sim_sdram_burst_seq.sv
`timescale 1ns/1ps
module sim_sdram_burst_seq;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        mrs_i = 1'b0;
    logic [11:0] addr_i = '0;
    logic        start_i = 1'b0;
    logic        start_write_i = 1'b0;
    logic [7:0]  start_col_i = '0;
    logic        stop_i = 1'b0;
    logic        dqm_i = 1'b0;
    logic [7:0]  col_o;
    logic        col_valid_o, wr_en_o, rd_valid_o, oe_o;

    sdram_burst_seq u0 (
        .clk(clk), .rst_n(rst_n), .mrs_i(mrs_i), .addr_i(addr_i),
        .start_i(start_i), .start_write_i(start_write_i),
        .start_col_i(start_col_i), .stop_i(stop_i), .dqm_i(dqm_i),
        .col_o(col_o), .col_valid_o(col_valid_o), .wr_en_o(wr_en_o),
        .rd_valid_o(rd_valid_o), .oe_o(oe_o)
    );

    always #5 clk = ~clk;

    int vectors = 0;
    int misses  = 0;
    int cyc     = 0;
    always @(posedge clk) cyc <= cyc + 1;

    typedef struct { int cy; logic [7:0] col; } beat_t;
    beat_t bq[$];
    int    rq[$];

    // bench mode model
    int m_bl = 0; bit m_fp = 0; bit m_bt = 0; int m_cl = 2; bit m_wbs = 0;
    bit    mon_on = 0;
    bit    cur_wr = 0;
    string cur_tag = "R1";
    logic  d1 = 0, d2 = 0;
    bit    here, rv;

    task automatic chk(input bit ok, input string tag, input string what,
                       input int act, input int exp);
        vectors++;
        if (!ok) begin
            misses++;
            $display("FAIL %s %s: actual %0d expected %0d (cycle %0d)", tag, what, act, exp, cyc);
        end
    endtask

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    function automatic logic [7:0] ecol(input int s, input int i);
        logic [7:0] sv, iv, m;
        sv = s[7:0];
        iv = i[7:0];
        if (m_fp) return sv + iv;
        m = 8'((1 << m_bl) - 1);
        return (sv & ~m) | ((m_bt ? (sv ^ iv) : (sv + iv)) & m);
    endfunction

    // monitor: compares every cycle against queued expectations
    always @(negedge clk) begin
        if (mon_on) begin
            here = (bq.size() > 0) && (bq[0].cy == cyc);
            chk(col_valid_o == here, cur_tag, "col_valid", col_valid_o, here);
            if (here) begin
                chk(col_o == bq[0].col, cur_tag, "column", col_o, bq[0].col);
                void'(bq.pop_front());
            end
            // R11
            chk(wr_en_o == (here && cur_wr && !dqm_i), "R11", "wr_en",
                wr_en_o, here && cur_wr && !dqm_i);
            rv = (rq.size() > 0) && (rq[0] == cyc);
            if (rv) void'(rq.pop_front());
            // R4
            chk(rd_valid_o == rv, "R4", "rd_valid", rd_valid_o, rv);
            // R12
            chk(oe_o == (rv && !d2), "R12", "oe", oe_o, rv && !d2);
            d2 = d1;
            d1 = dqm_i;
        end
    end

    task automatic do_mrs(input logic [11:0] a);
        int bl, cl;
        bit ok;
        bl = int'(a[2:0]);
        cl = int'(a[6:4]);
        ok = (a[8:7] == 2'b00) && (bl <= 3 || bl == 7) && (cl == 2 || cl == 3)
             && !(bl == 7 && a[3]);
        step();
        mrs_i = 1'b1;
        addr_i = a;
        step();
        mrs_i = 1'b0;
        if (ok) begin
            m_fp = (bl == 7);
            m_bl = m_fp ? 0 : bl;
            m_bt = a[3];
            m_cl = cl;
            m_wbs = a[9];
        end
    endtask

    task automatic burst(input bit wr, input int col, input int stop_at,
                         input bit poke, input logic [31:0] dm, input string tag);
        int len, t;
        if (wr && m_wbs)  len = 1;
        else if (m_fp)    len = stop_at + 1;
        else              len = 1 << m_bl;
        if (stop_at >= 0 && stop_at + 1 < len) len = stop_at + 1;
        step();
        cur_tag = tag;
        cur_wr = wr;
        start_i = 1'b1;
        start_write_i = wr;
        start_col_i = col[7:0];
        t = cyc;
        for (int i = 0; i < len; i++) begin
            bq.push_back('{t + 1 + i, ecol(col, i)});
            if (!wr) rq.push_back(t + 1 + i + m_cl);
        end
        step();
        start_i = 1'b0;
        for (int i = 0; i < len; i++) begin
            dqm_i = (i < 32) ? dm[i] : 1'b0;
            stop_i = (i == stop_at);
            if (poke && i == 1) begin
                start_i = 1'b1;
                start_write_i = ~wr;
                start_col_i = 8'h55;
                mrs_i = 1'b1;
                addr_i = 12'h020;
            end
            step();
            stop_i = 1'b0;
            start_i = 1'b0;
            mrs_i = 1'b0;
            dqm_i = 1'b0;
        end
        repeat (m_cl + 3) step();
        chk(bq.size() == 0 && rq.size() == 0, tag, "beats left over",
            bq.size() + rq.size(), 0);
        bq.delete();
        rq.delete();
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        misses++;
        $display("FAIL watchdog expired at cycle %0d", cyc);
        $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
        $finish;
    end

    initial begin
        repeat (3) step();
        rst_n = 1'b1;
        step();
        // R1 reset state
        chk(!col_valid_o && !wr_en_o && !rd_valid_o && !oe_o, "R1", "idle outputs",
            {col_valid_o, wr_en_o, rd_valid_o, oe_o}, 0);
        mon_on = 1;
        burst(0, 5, -1, 0, '0, "R1");
        burst(1, 5, -1, 0, '0, "R1");

        // R7 sequential BL4 CL2, mask on beat 2
        do_mrs(12'h022);
        burst(0, 6, -1, 0, 32'b0100, "R7");

        // R8 interleaved BL8 CL3
        do_mrs(12'h03B);
        burst(0, 'h15, -1, 0, 32'b1000, "R8");

        // R11 BL2 write with mask on second beat
        do_mrs(12'h021);
        burst(1, 9, -1, 0, 32'b10, "R11");

        // R6 single-beat writes, full-length reads
        do_mrs(12'h233);
        burst(1, 3, -1, 0, '0, "R6");
        burst(0, 3, -1, 0, 32'b0010_0001, "R6");

        // reserved codes leave mode unchanged
        do_mrs(12'h1A1);
        burst(0, 2, -1, 0, '0, "R5");
        do_mrs(12'h024);
        burst(0, 2, -1, 0, '0, "R2");
        do_mrs(12'h013);
        burst(0, 2, -1, 0, '0, "R4");
        do_mrs(12'h02F);
        burst(0, 2, -1, 0, '0, "R3");

        // R9 full page wrap and run past 256 beats
        do_mrs(12'h027);
        burst(0, 250, 10, 0, '0, "R9");
        burst(1, 7, 299, 0, 32'h0000_F00F, "R9");

        // R10 stop inside fixed-length bursts
        do_mrs(12'h033);
        burst(0, 0, 2, 0, '0, "R10");
        burst(1, 4, 4, 0, '0, "R10");
        burst(0, 1, 0, 0, '0, "R10");

        // R13 start and MRS during a burst are dropped
        burst(0, 'h2C, -1, 1, '0, "R13");
        burst(1, 1, -1, 1, '0, "R13");

        // R8 interleaved BL4 writes, R2 back to BL1
        do_mrs(12'h03A);
        burst(1, 'h0E, -1, 0, 32'b0001, "R8");
        do_mrs(12'h020);
        burst(0, 'h33, -1, 0, '0, "R2");

        mon_on = 0;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
        $finish;
    end

endmodule